// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Register

This block keeps the status word of one channel of a descriptor-chaining DMA engine. The channel datapath reports what happens through single-cycle event strobes: a start (or restart) of the channel, a software halt, an abort, completion of a segment, completion of the final list descriptor, completion of the final link descriptor, a transfer error and a programming error. The block turns these into sticky event flags, a busy flag and a halted flag. It also drives a single interrupt line.

The interrupt-enable inputs come from the mode register and the current link descriptor, and they decide whether a completion event is recorded. In chaining mode the segment-done flag is recorded when either the mode enable or the descriptor enable is set. In direct mode only the mode enable counts. Software reads the status word through a simple register bus. It clears sticky flags by writing 1 to their positions. Writing 0 does nothing, and the busy and halted flags cannot be written.

The status fields sit in the low byte of a 32-bit word. They use little-endian bit numbers: bit 7 end-of-links, bit 6 end-of-list, bit 5 end-of-segment, bit 4 reserved, bit 3 halted, bit 2 busy, bit 1 transfer error, bit 0 programming error.

Top module: `dma_chan_stat`

## Requirements
- R1: After reset the whole status word reads 0 and `irq` is 0.
- R2: A `ev_xfer_err` strobe sets bit 1 (transfer error), whatever the enables are. The bit stays set until software writes 1 to bit 1.
- R3: A `ev_prog_err` strobe sets bit 0 (programming error), whatever the enables are. The bit stays set until software writes 1 to bit 0.
- R4: `ev_start` on an idle, non-halted channel sets bit 2 (busy). Busy clears on any of these: completion (in direct mode `ev_seg_done`, in chaining mode `ev_list_done`), a transfer or programming error, or an abort.
- R5: `ev_halt` while busy clears busy and sets bit 3 (halted). A later `ev_start` clears halted and sets busy again.
- R6: `ev_halt` on an idle channel leaves halted at 0.
- R7: `ev_seg_done` sets bit 5 when `mode_chain`=1 and (`mr_seg_ien` or `desc_seg_ien`) is set. It also sets bit 5 when `mode_chain`=0 and `mr_seg_ien` is set. Otherwise bit 5 is unchanged.
- R8: `ev_list_done` sets bit 6, and `ev_link_done` sets bit 7, each only when `mr_end_ien` is 1.
- R9: A write with bit k set clears sticky bit k, for k in {0,1,5,6,7}. Writing 0 has no effect. Writes to bits 2, 3, 4 and 31:8 have no effect, and bits 4 and 31:8 always read 0.
- R10: `irq` is 1 exactly when at least one of bits 0, 1, 5, 6, 7 is set.
- R11: When a hardware set and a software clear hit the same sticky bit in the same cycle, the bit ends up set.
- R12: `ev_abort` clears both busy and halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Channel start or resume strobe |
| ev_halt | input | 1 | Software halt strobe |
| ev_abort | input | 1 | Channel abort strobe |
| ev_seg_done | input | 1 | Segment transfer finished |
| ev_list_done | input | 1 | Last list descriptor finished |
| ev_link_done | input | 1 | Last link descriptor finished |
| ev_xfer_err | input | 1 | Error during transfer |
| ev_prog_err | input | 1 | Programming error detected |
| mode_chain | input | 1 | 1 = chaining mode, 0 = direct mode |
| mr_seg_ien | input | 1 | Mode-register segment interrupt enable |
| desc_seg_ien | input | 1 | Link-descriptor segment interrupt enable |
| mr_end_ien | input | 1 | End-of-list/links interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data (1 = clear) |
| reg_rdata | output | 32 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all sixteen combinations of mode and enable inputs against each completion event. This catches segment gating that forgets the descriptor enable in chaining mode, or that lets it through in direct mode. Each sticky bit is cleared on its own, so a wrong field position would clear a neighbour. Writes of zeros and writes to busy, halted and reserved positions are shown to leave the word unchanged. A same-cycle set and clear must leave the bit set; a design where the clear wins would drop the event. The run-state sequences cover halting an idle channel (which must not show halted), resuming after a halt, finishing in each mode, and aborting a halted channel. A design that finished on the wrong event, or kept halted after an abort, would show a stale busy or halted flag.

// File: rtl/dma_stat_pkg.sv
// Package: field positions and widths of the channel status word.
// Assumes little-endian bit numbering of a 32-bit word.
package dma_stat_pkg;
    localparam int unsigned STAT_W   = 32;
    localparam int unsigned N_STICKY = 5;

    // Status word bit positions
    localparam int unsigned B_PERR = 0;
    localparam int unsigned B_TERR = 1;
    localparam int unsigned B_BUSY = 2;
    localparam int unsigned B_HALT = 3;
    localparam int unsigned B_RSVD = 4;
    localparam int unsigned B_SEG  = 5;
    localparam int unsigned B_LIST = 6;
    localparam int unsigned B_LINK = 7;

    // Index of each sticky flag inside the sticky bank
    localparam int unsigned S_PERR = 0;
    localparam int unsigned S_TERR = 1;
    localparam int unsigned S_SEG  = 2;
    localparam int unsigned S_LIST = 3;
    localparam int unsigned S_LINK = 4;

    // Word position for each sticky index
    function automatic int unsigned sticky_pos(input int unsigned idx);
        case (idx)
            S_PERR:  return B_PERR;
            S_TERR:  return B_TERR;
            S_SEG:   return B_SEG;
            S_LIST:  return B_LIST;
            default: return B_LINK;
        endcase
    endfunction
endpackage

// File: rtl/dma_stat_event_qual.sv
// Qualifies raw datapath event strobes with the interrupt enables and the
// channel mode, producing one set request per sticky flag.
// Assumes event strobes are single-cycle and already synchronous to clk.
module dma_stat_event_qual
    import dma_stat_pkg::*;
(
    input  logic                ev_seg_done,
    input  logic                ev_list_done,
    input  logic                ev_link_done,
    input  logic                ev_xfer_err,
    input  logic                ev_prog_err,
    input  logic                mode_chain,
    input  logic                mr_seg_ien,
    input  logic                desc_seg_ien,
    input  logic                mr_end_ien,
    output logic [N_STICKY-1:0] set_req
);
    logic seg_en;

    // Segment enable: descriptor enable only counts in chaining mode
    always_comb begin
        seg_en = mr_seg_ien | (mode_chain & desc_seg_ien);
    end

    // Build the set-request vector per sticky index
    always_comb begin
        set_req         = '0;
        set_req[S_PERR] = ev_prog_err;
        set_req[S_TERR] = ev_xfer_err;
        set_req[S_SEG]  = ev_seg_done & seg_en;
        set_req[S_LIST] = ev_list_done & mr_end_ien;
        set_req[S_LINK] = ev_link_done & mr_end_ien;
    end
endmodule

// File: rtl/dma_stat_sticky.sv
// Bank of write-one-to-clear sticky flags; a hardware set in the same
// cycle as a clear wins. Assumes synchronous active-low reset.
module dma_stat_sticky #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One sticky flag: set has priority over software clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_req[i])
                flags[i] <= 1'b1;
            else if (clr_req[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_stat_run_ctl.sv
// Tracks the busy and halted flags of the channel from run-control strobes.
// Priority: abort, then error/completion, then halt, then start.
// Assumes strobes are single-cycle; start while halted acts as resume.
module dma_stat_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start,
    input  logic ev_halt,
    input  logic ev_abort,
    input  logic ev_seg_done,
    input  logic ev_list_done,
    input  logic ev_xfer_err,
    input  logic ev_prog_err,
    input  logic mode_chain,
    output logic busy,
    output logic halted
);
    logic finish;
    logic stop;

    // Completion event depends on the channel mode
    always_comb begin
        finish = mode_chain ? ev_list_done : ev_seg_done;
        stop   = finish | ev_xfer_err | ev_prog_err;
    end

    // Busy/halted state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            halted <= 1'b0;
        end else if (ev_abort) begin
            busy   <= 1'b0;
            halted <= 1'b0;
        end else if (stop) begin
            busy   <= 1'b0;
        end else if (ev_halt && busy) begin
            busy   <= 1'b0;
            halted <= 1'b1;
        end else if (ev_start && (halted || !busy)) begin
            busy   <= 1'b1;
            halted <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_chan_stat.sv
// Per-channel DMA status register: sticky event flags, busy/halted flags,
// write-one-to-clear register access and one interrupt line.
// Assumes single-register bus (no address) and combinational read data.
module dma_chan_stat
    import dma_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_halt,
    input  logic              ev_abort,
    input  logic              ev_seg_done,
    input  logic              ev_list_done,
    input  logic              ev_link_done,
    input  logic              ev_xfer_err,
    input  logic              ev_prog_err,
    input  logic              mode_chain,
    input  logic              mr_seg_ien,
    input  logic              desc_seg_ien,
    input  logic              mr_end_ien,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              irq
);
    logic [N_STICKY-1:0] set_req;
    logic [N_STICKY-1:0] clr_req;
    logic [N_STICKY-1:0] flags;
    logic                busy;
    logic                halted;
    logic                wdata_unused;

    dma_stat_event_qual i_qual (
        .ev_seg_done  (ev_seg_done),
        .ev_list_done (ev_list_done),
        .ev_link_done (ev_link_done),
        .ev_xfer_err  (ev_xfer_err),
        .ev_prog_err  (ev_prog_err),
        .mode_chain   (mode_chain),
        .mr_seg_ien   (mr_seg_ien),
        .desc_seg_ien (desc_seg_ien),
        .mr_end_ien   (mr_end_ien),
        .set_req      (set_req)
    );

    // Map write data onto per-flag clear requests
    for (genvar i = 0; i < N_STICKY; i++) begin : g_clr
        assign clr_req[i] = reg_wr & reg_wdata[sticky_pos(i)];
    end

    // Bits with no write effect
    assign wdata_unused = ^{reg_wdata[STAT_W-1:B_LINK+1], reg_wdata[B_RSVD],
                            reg_wdata[B_HALT], reg_wdata[B_BUSY]};

    dma_stat_sticky #(.N(N_STICKY)) i_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .flags   (flags)
    );

    dma_stat_run_ctl i_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_start     (ev_start),
        .ev_halt      (ev_halt),
        .ev_abort     (ev_abort),
        .ev_seg_done  (ev_seg_done),
        .ev_list_done (ev_list_done),
        .ev_xfer_err  (ev_xfer_err),
        .ev_prog_err  (ev_prog_err),
        .mode_chain   (mode_chain),
        .busy         (busy),
        .halted       (halted)
    );

    // Assemble the status word; reserved positions read 0
    always_comb begin
        reg_rdata         = '0;
        reg_rdata[B_PERR] = flags[S_PERR];
        reg_rdata[B_TERR] = flags[S_TERR];
        reg_rdata[B_BUSY] = busy;
        reg_rdata[B_HALT] = halted;
        reg_rdata[B_SEG]  = flags[S_SEG];
        reg_rdata[B_LIST] = flags[S_LIST];
        reg_rdata[B_LINK] = flags[S_LINK];
    end

    // Interrupt is the OR of all sticky flags
    assign irq = |flags;
endmodule

// File: rtl/dma_chan_stat_chk.sv
// Checker for dma_chan_stat, attached by bind; observes ports only.
module dma_chan_stat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_start,
    input logic        ev_halt,
    input logic        ev_abort,
    input logic        ev_seg_done,
    input logic        ev_list_done,
    input logic        ev_link_done,
    input logic        ev_xfer_err,
    input logic        ev_prog_err,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        irq
);
    assert_busy_halt_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rdata[2] && reg_rdata[3]));

    assert_idle_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_halt && !reg_rdata[2] && !reg_rdata[3] && !ev_start) |=> !reg_rdata[3]);

    assert_terr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_xfer_err |=> reg_rdata[1]);

    assert_perr_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_prog_err && reg_wr && reg_wdata[0]) |=> reg_rdata[0]);

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:8] == 24'd0) && !reg_rdata[4]);

    assert_irq_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_xfer_err || ev_prog_err || ev_seg_done ||
                             ev_list_done || ev_link_done));

    assert_halt_fall_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[3]) |-> $past(ev_start || ev_abort));

    assert_busy_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[2]) |-> $past(ev_abort || ev_xfer_err || ev_prog_err ||
                                      ev_halt || ev_seg_done || ev_list_done));
endmodule

bind dma_chan_stat dma_chan_stat_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_start     (ev_start),
    .ev_halt      (ev_halt),
    .ev_abort     (ev_abort),
    .ev_seg_done  (ev_seg_done),
    .ev_list_done (ev_list_done),
    .ev_link_done (ev_link_done),
    .ev_xfer_err  (ev_xfer_err),
    .ev_prog_err  (ev_prog_err),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq          (irq)
);

// File: tb/test_dma_chan_stat.sv
// Self-checking bench for dma_chan_stat: enable/mode sweep, clear sweep,
// run-state sequences. Inputs change on negedge; outputs sampled on negedge.
module test_dma_chan_stat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_start = 0, ev_halt = 0, ev_abort = 0, ev_seg_done = 0;
    logic        ev_list_done = 0, ev_link_done = 0, ev_xfer_err = 0, ev_prog_err = 0;
    logic        mode_chain = 0, mr_seg_ien = 0, desc_seg_ien = 0, mr_end_ien = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;   // 250 MHz

    dma_chan_stat i_dma_chan_stat (.*);

    // Event vector: 0 start,1 halt,2 abort,3 seg,4 list,5 link,6 xerr,7 perr
    task automatic step(input logic [7:0] ev, input logic wr, input logic [31:0] wd);
        @(negedge clk);
        {ev_prog_err, ev_xfer_err, ev_link_done, ev_list_done,
         ev_seg_done, ev_abort, ev_halt, ev_start} = ev;
        reg_wr = wr; reg_wdata = wd;
        @(negedge clk);
        {ev_prog_err, ev_xfer_err, ev_link_done, ev_list_done,
         ev_seg_done, ev_abort, ev_halt, ev_start} = '0;
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [31:0] exp);
        chk(req, reg_rdata, exp);
        chk({req, " irq"}, {31'd0, irq}, {31'd0, |(exp & 32'hE3)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_word("R1 reset", 32'h0);
        rst_n = 1;

        // R7/R8/R10 sweep over mode and enables
        for (int c = 0; c < 16; c++) begin
            logic exp_seg;
            {mode_chain, mr_seg_ien, desc_seg_ien, mr_end_ien} = c[3:0];
            exp_seg = mode_chain ? (mr_seg_ien | desc_seg_ien) : mr_seg_ien;
            step(8'h00, 1, 32'hFF);
            step(8'h08, 0, 0);
            chk_word("R7 seg gating", {26'd0, exp_seg, 5'd0});
            step(8'h00, 1, 32'hFF);
            step(8'h10, 0, 0);
            chk_word("R8 list gating", {25'd0, mr_end_ien, 6'd0});
            step(8'h00, 1, 32'hFF);
            step(8'h20, 0, 0);
            chk_word("R8 link gating", {24'd0, mr_end_ien, 7'd0});
        end

        // Set all sticky flags (direct mode, everything enabled)
        {mode_chain, mr_seg_ien, desc_seg_ien, mr_end_ien} = 4'b0101;
        step(8'h00, 1, 32'hFF);
        step(8'hF8, 0, 0);
        chk_word("R2 R3 all set", 32'hE3);
        step(8'h00, 1, 32'h0);
        chk_word("R9 write zero", 32'hE3);
        step(8'h00, 1, 32'hFFFF_FF1C);
        chk_word("R9 non-sticky write", 32'hE3);
        // Clear each sticky flag alone
        begin
            logic [31:0] remain;
            int pos [5] = '{0, 1, 5, 6, 7};
            remain = 32'hE3;
            foreach (pos[k]) begin
                step(8'h00, 1, 32'h1 << pos[k]);
                remain[pos[k]] = 1'b0;
                chk_word("R9 single clear", remain);
            end
        end
        chk({"R10 irq low"}, {31'd0, irq}, 32'd0);

        // R11 set wins over same-cycle clear
        step(8'h40, 1, 32'h2);
        chk_word("R11 terr set wins", 32'h2);
        step(8'h80, 1, 32'h3);
        chk_word("R11 perr set wins, R2 terr cleared", 32'h1);
        step(8'h00, 1, 32'h1);
        chk_word("R3 perr cleared", 32'h0);

        // Run-state sequences, enables off so no sticky flags appear
        {mode_chain, mr_seg_ien, desc_seg_ien, mr_end_ien} = 4'b1000;
        step(8'h02, 0, 0);
        chk_word("R6 idle halt", 32'h0);
        step(8'h01, 0, 0);
        chk_word("R4 start busy", 32'h4);
        step(8'h00, 1, 32'h0C);
        chk_word("R9 busy not writable", 32'h4);
        step(8'h02, 0, 0);
        chk_word("R5 halted", 32'h8);
        step(8'h02, 0, 0);
        chk_word("R5 halt again stays", 32'h8);
        step(8'h01, 0, 0);
        chk_word("R5 resume", 32'h4);
        step(8'h08, 0, 0);
        chk_word("R4 chain seg not finish", 32'h4);
        step(8'h10, 0, 0);
        chk_word("R4 chain list finish", 32'h0);
        mode_chain = 0;
        step(8'h01, 0, 0);
        step(8'h10, 0, 0);
        chk_word("R4 direct list not finish", 32'h4);
        step(8'h08, 0, 0);
        chk_word("R4 direct seg finish", 32'h0);
        step(8'h01, 0, 0);
        step(8'h40, 0, 0);
        chk_word("R4 R2 error ends busy", 32'h2);
        step(8'h01, 1, 32'h2);
        step(8'h04, 0, 0);
        chk_word("R12 abort busy", 32'h0);
        step(8'h01, 0, 0);
        step(8'h02, 0, 0);
        step(8'h04, 0, 0);
        chk_word("R12 abort halted", 32'h0);
        step(8'h80, 0, 0);
        chk_word("R3 perr idle", 32'h1);

        done = 1;
    end

    // Watchdog and summary
    initial begin
        for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule